// File: doc/BRIEF.md
# Auto-Increment Word Program Sequencer

This block writes a run of bytes into a serial NOR flash that accepts two-byte programming with automatic address increment. The host gives a start address, a byte count and a stream of data bytes. The sequencer turns the request into a series of command frames. A frame goes out as a stream of bytes to a byte-level serial master, and the master raises chip select for the last byte of each frame. After each frame that starts an internal flash operation, the block runs a status poll through a separate request/answer port.

A write always begins with a write-enable frame. An odd start address is handled first with a single-byte program. Whole byte pairs then go out in auto-increment mode. Only the first of these pair frames carries the address. A write-disable frame closes the mode. If one byte is left over, it is written with its own write-enable, single-byte program and write-disable. A poll that stays busy too long ends the job with an error. The number of data bytes written is reported when the job finishes.

Top module: `aai_word_seq`

## Requirements
- R1: During and right after reset the block is idle: `busy`, `done`, `tx_valid`, `din_ready` and `poll_req` are all low.
- R2: A start with `length` zero sends no frame and no poll. It pulses `done` with `err` low and `written` zero.
- R3: Every job with a non-zero length begins with the one-byte frame 0x06 (write enable). No poll follows this frame.
- R4: When the start address is odd, the next frame is 0x02, then the address high byte, middle byte and low byte, then one data byte. The address then moves on by one.
- R5: A pair frame starts with opcode 0xAD. The first pair frame of a job has the three address bytes (high first) and then two data bytes. Every later pair frame has only the opcode and two data bytes.
- R6: After each single-byte program frame, each pair frame and the mode-ending write-disable frame, `poll_req` is pulsed. It is pulsed again for each busy answer, and no further frame starts until a not-busy answer arrives. Frames and poll requests never overlap.
- R7: After the last whole pair, or right after the head byte when no pair fits, the one-byte frame 0x04 (write disable) is sent and then polled.
- R8: If one byte remains after the pairs, the frames 0x06, then 0x02 with the byte's full address and the byte, then a poll, then 0x04 are sent, and the job ends without a further poll.
- R9: When `MAX_POLLS` answers in a row are busy, the job stops at once. It sends no further frame and pulses `done` with `err` high.
- R10: `done` is a one-cycle pulse. At that pulse `written` holds the number of data bytes sent, not counting opcode or address bytes.
- R11: The address moves on by 1 per single byte and by 2 per pair. A head or tail byte is sent at the address where it belongs, including when the address carries into a higher byte.
- R12: In a data slot, `tx_valid` follows `din_valid` and `din_ready` follows `tx_ready`. Stalls on either side lose, repeat or reorder no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start a job (taken when idle) |
| start_addr | input | ADDR_W | First flash address |
| length | input | LEN_W | Number of bytes to write |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| err | output | 1 | Status poll timed out (valid at `done`) |
| written | output | LEN_W | Data bytes sent in this job |
| din_valid | input | 1 | Data byte available |
| din_data | input | 8 | Data byte |
| din_ready | output | 1 | Data byte taken |
| tx_valid | output | 1 | Frame byte valid toward the serial master |
| tx_data | output | 8 | Frame byte |
| tx_end | output | 1 | Last byte of the frame |
| tx_ready | input | 1 | Serial master accepts the byte |
| poll_req | output | 1 | One-cycle request for a status read |
| poll_ack | input | 1 | Status answer valid |
| poll_busy | input | 1 | Flash still busy (with `poll_ack`) |

## Verification
The bench builds the block with its default 24-bit address and 16-bit length, and sets `MAX_POLLS` to 4. That small limit makes the timeout reachable with a few busy answers, and it is large enough that two busy answers per poll in normal jobs still finish without error. The vector table covers even and odd starts and lengths, carries across an address byte, one-byte jobs of both parities, and stalls on both the master and data sides. Every check compares the exact frame stream with poll markers against a model built from the requirements.

// File: rtl/aai_pkg.sv
// Shared opcodes and state types of the auto-increment word program sequencer.
// Assumes byte-wide serial frames with the address sent high byte first.
package aai_pkg;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_BYTE = 8'h02;
    localparam logic [7:0] OP_PAIR = 8'hAD;

    typedef enum logic [2:0] {S_IDLE, S_SEND, S_POLL_REQ, S_POLL_WAIT, S_FIN} seq_state_e;
    typedef enum logic [2:0] {P_WREN, P_HEAD, P_PAIR, P_WRDI, P_TWREN, P_TAIL, P_TWRDI, P_END} phase_e;
    typedef enum logic [1:0] {F_CMD, F_BYTE, F_PAIR_A, F_PAIR} frame_e;
endpackage

// File: rtl/aai_frame_builder.sv
// Frame layout decoder: for a frame kind and byte index it gives the header byte
// (opcode or address byte), whether the slot carries data, and whether it is last.
// Assumes ADDR_W is a multiple of 8.
module aai_frame_builder
    import aai_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int IDX_W  = 3
) (
    input  frame_e            kind,
    input  logic [7:0]        opcode,
    input  logic [IDX_W-1:0]  idx,
    input  logic [ADDR_W-1:0] addr,
    output logic [7:0]        hdr_byte,
    output logic              is_data,
    output logic              is_last
);
    localparam int AB = ADDR_W / 8;

    int n_addr;
    int n_data;

    // Count address and data slots for the frame kind.
    always_comb begin
        case (kind)
            F_BYTE:   begin n_addr = AB; n_data = 1; end
            F_PAIR_A: begin n_addr = AB; n_data = 2; end
            F_PAIR:   begin n_addr = 0;  n_data = 2; end
            default:  begin n_addr = 0;  n_data = 0; end
        endcase
    end

    // Classify the slot and pick the header byte, address high byte first.
    always_comb begin
        is_last  = (int'(idx) == n_addr + n_data);
        is_data  = (int'(idx) > n_addr);
        hdr_byte = opcode;
        for (int k = 1; k <= AB; k++) begin
            if (int'(idx) == k) hdr_byte = addr[(AB-k)*8 +: 8];
        end
    end
endmodule

// File: rtl/aai_poll_timer.sv
// Counts busy answers in a row during one status poll and flags the answer
// that reaches MAX_POLLS. Assumes clear is pulsed before each new poll run.
module aai_poll_timer #(
    parameter int MAX_POLLS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic hit,
    output logic expired
);
    localparam int CW = $clog2(MAX_POLLS + 1);

    logic [CW-1:0] cnt;

    // The answer that reaches the limit is the expiring one.
    assign expired = hit && (cnt == CW'(MAX_POLLS - 1));

    // Count busy answers in a row, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else if (hit && !expired) cnt <= cnt + 1'b1;
    end

    AST_POLL_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(MAX_POLLS)); // R9
endmodule

// File: rtl/aai_word_seq.sv
// Auto-increment word program sequencer. Turns (start_addr, length, data stream)
// into write-enable, head byte, pair, write-disable and tail frames, with
// status polls in between. Assumes the serial master frames one byte per
// tx_valid/tx_ready handshake and ends chip select on tx_end.
module aai_word_seq
    import aai_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int LEN_W     = 16,
    parameter int MAX_POLLS = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  length,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [LEN_W-1:0]  written,
    input  logic              din_valid,
    input  logic [7:0]        din_data,
    output logic              din_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_end,
    input  logic              tx_ready,
    output logic              poll_req,
    input  logic              poll_ack,
    input  logic              poll_busy
);
    localparam int IDX_W = $clog2(ADDR_W / 8 + 4);

    seq_state_e        state;
    phase_e            phase, after_poll, nxt_phase;
    frame_e            kind;
    logic [7:0]        opcode, hdr_byte;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  rem, rem_n, len_q;
    logic              first_pair, is_data, is_last, fire, data_fire, frame_end;
    logic              need_poll, poll_hit, poll_expired;

    // Pick the frame kind and opcode for the current phase.
    always_comb begin
        case (phase)
            P_WREN, P_TWREN: begin kind = F_CMD;  opcode = OP_WREN; end
            P_HEAD, P_TAIL:  begin kind = F_BYTE; opcode = OP_BYTE; end
            P_PAIR:          begin kind = first_pair ? F_PAIR_A : F_PAIR; opcode = OP_PAIR; end
            default:         begin kind = F_CMD;  opcode = OP_WRDI; end
        endcase
    end

    aai_frame_builder #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_frame (
        .kind(kind), .opcode(opcode), .idx(idx), .addr(addr),
        .hdr_byte(hdr_byte), .is_data(is_data), .is_last(is_last)
    );

    // Byte handshake toward the serial master, data passed through in data slots.
    always_comb begin
        tx_valid  = 1'b0;
        tx_data   = 8'h00;
        tx_end    = 1'b0;
        din_ready = 1'b0;
        if (state == S_SEND) begin
            tx_valid  = is_data ? din_valid : 1'b1;
            tx_data   = is_data ? din_data : hdr_byte;
            tx_end    = is_last;
            din_ready = is_data && tx_ready;
        end
    end

    assign fire      = tx_valid && tx_ready;
    assign data_fire = fire && is_data;
    assign frame_end = fire && is_last;
    assign rem_n     = rem - (data_fire ? LEN_W'(1) : LEN_W'(0));

    // Decide what follows the frame that ends now, and whether a poll comes first.
    always_comb begin
        need_poll = 1'b0;
        nxt_phase = P_END;
        case (phase)
            P_WREN:         nxt_phase = addr[0] ? P_HEAD : ((rem >= LEN_W'(2)) ? P_PAIR : P_WRDI);
            P_HEAD, P_PAIR: begin
                need_poll = 1'b1;
                nxt_phase = (rem_n >= LEN_W'(2)) ? P_PAIR : P_WRDI;
            end
            P_WRDI: begin
                need_poll = 1'b1;
                nxt_phase = (rem == LEN_W'(1)) ? P_TWREN : P_END;
            end
            P_TWREN:        nxt_phase = P_TAIL;
            P_TAIL: begin
                need_poll = 1'b1;
                nxt_phase = P_TWRDI;
            end
            default:        nxt_phase = P_END;
        endcase
    end

    assign poll_hit = (state == S_POLL_WAIT) && poll_ack && poll_busy;

    aai_poll_timer #(.MAX_POLLS(MAX_POLLS)) i_timer (
        .clk(clk), .rst_n(rst_n),
        .clear(state == S_SEND && frame_end && need_poll),
        .hit(poll_hit), .expired(poll_expired)
    );

    assign busy     = (state != S_IDLE);
    assign done     = (state == S_FIN);
    assign poll_req = (state == S_POLL_REQ);

    // Main sequencing: job start, frame progress, poll handling, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            phase      <= P_WREN;
            after_poll <= P_END;
            idx        <= '0;
            addr       <= '0;
            rem        <= '0;
            len_q      <= '0;
            written    <= '0;
            err        <= 1'b0;
            first_pair <= 1'b1;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    addr       <= start_addr;
                    rem        <= length;
                    len_q      <= length;
                    written    <= '0;
                    err        <= 1'b0;
                    idx        <= '0;
                    first_pair <= 1'b1;
                    phase      <= P_WREN;
                    state      <= (length == '0) ? S_FIN : S_SEND;
                end
                S_SEND: if (fire) begin
                    idx <= is_last ? '0 : idx + 1'b1;
                    if (data_fire) begin
                        addr    <= addr + ADDR_W'(1);
                        rem     <= rem_n;
                        written <= written + LEN_W'(1);
                    end
                    if (is_last) begin
                        if (phase == P_PAIR) first_pair <= 1'b0;
                        if (need_poll) begin
                            after_poll <= nxt_phase;
                            state      <= S_POLL_REQ;
                        end else if (nxt_phase == P_END) begin
                            state <= S_FIN;
                        end else begin
                            phase <= nxt_phase;
                        end
                    end
                end
                S_POLL_REQ: state <= S_POLL_WAIT;
                S_POLL_WAIT: if (poll_ack) begin
                    if (!poll_busy) begin
                        if (after_poll == P_END) state <= S_FIN;
                        else begin
                            phase <= after_poll;
                            state <= S_SEND;
                        end
                    end else if (poll_expired) begin
                        err   <= 1'b1;
                        state <= S_FIN;
                    end else begin
                        state <= S_POLL_REQ;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid && poll_req)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_BYTE_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SEND) |-> (written + rem == len_q)); // R10
    AST_ABORT_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_hit && poll_expired) |=> (done && err)); // R9
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        data_fire |=> (addr == $past(addr) + ADDR_W'(1))); // R11
endmodule

// File: tb/test_aai_word_seq.sv
module test_aai_word_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] start_addr = '0;
    logic [15:0] length = '0;
    logic        busy, done, err, din_ready, tx_valid, tx_end, poll_req;
    logic [15:0] written;
    logic [7:0]  tx_data;
    logic        din_valid = 1'b0, tx_ready = 1'b0, poll_ack = 1'b0, poll_busy = 1'b0;
    logic [7:0]  din_data = 8'h00;

    always #4 clk = ~clk;

    aai_word_seq #(.ADDR_W(24), .LEN_W(16), .MAX_POLLS(4)) i_aai_word_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .length(length),
        .busy(busy), .done(done), .err(err), .written(written),
        .din_valid(din_valid), .din_data(din_data), .din_ready(din_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_end(tx_end), .tx_ready(tx_ready),
        .poll_req(poll_req), .poll_ack(poll_ack), .poll_busy(poll_busy)
    );

    // Entry: [9] poll-ready marker, [8] frame end, [7:0] byte.
    localparam logic [9:0] MARK = 10'h200;
    logic [9:0] cap [128];
    logic [9:0] exp_s [128];
    int cap_n, exp_n;
    int n_chk = 0, n_fail = 0;
    int cyc = 0, di_ptr = 0, cur_len = 0, busy_k = 0, busy_seen = 0;
    logic stall = 0, gap = 0, pend_ack = 0, pend_busy = 0;
    logic seen_done = 0, seen_err = 0;
    logic [15:0] seen_cnt = '0;
    logic [7:0] seed = 8'h00;

    function automatic logic [7:0] pat(input int i, input logic [7:0] s);
        return 8'(i * 37) + s;
    endfunction

    // Vectors: addr[63:40] len[39:24] busy answers[23:16] stall[15:8] gap[7:0]
    localparam int NV = 7;
    localparam logic [63:0] VEC [NV] = '{
        {24'h000100, 16'd4, 8'd0, 8'd0, 8'd0},
        {24'h000101, 16'd4, 8'd1, 8'd0, 8'd0},
        {24'h000101, 16'd5, 8'd0, 8'd1, 8'd0},
        {24'h000100, 16'd1, 8'd2, 8'd0, 8'd0},
        {24'h000103, 16'd1, 8'd0, 8'd0, 8'd1},
        {24'h0000FF, 16'd2, 8'd1, 8'd1, 8'd1},
        {24'h12FFFE, 16'd7, 8'd0, 8'd1, 8'd1}
    };

    // Device and data-source model: drive after negedge, sample before posedge.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            poll_ack  = pend_ack;
            poll_busy = pend_busy;
            pend_ack  = 1'b0;
            din_valid = (di_ptr < cur_len) && !(gap && (cyc % 4 == 2));
            din_data  = pat(di_ptr, seed);
            tx_ready  = !(stall && (cyc % 3 == 1));
            #1;
            if (tx_valid && tx_ready && cap_n < 128) begin cap[cap_n] = {1'b0, tx_end, tx_data}; cap_n++; end
            if (din_valid && din_ready) di_ptr++;
            if (poll_ack && !poll_busy && cap_n < 128) begin cap[cap_n] = MARK; cap_n++; end
            if (poll_req) begin
                pend_ack = 1'b1;
                if (busy_seen < busy_k) begin pend_busy = 1'b1; busy_seen++; end
                else begin pend_busy = 1'b0; busy_seen = 0; end
            end
            if (done) begin seen_done = 1'b1; seen_err = err; seen_cnt = written; end
        end
    end

    task automatic push(input logic [9:0] e);
        exp_s[exp_n] = e;
        exp_n++;
    endtask

    task automatic push_addr(input logic [23:0] a);
        push({2'b00, a[23:16]}); push({2'b00, a[15:8]}); push({2'b00, a[7:0]});
    endtask

    // Expected frame stream built from R3..R8 and R11.
    task automatic gen_expected(input logic [23:0] a0, input int len);
        logic [23:0] a;
        int r, d;
        logic first;
        exp_n = 0;
        if (len == 0) return;
        a = a0; r = len; d = 0; first = 1'b1;
        push({2'b01, 8'h06});
        if (a[0]) begin
            push({2'b00, 8'h02}); push_addr(a); push({2'b01, pat(d, seed)}); d++;
            push(MARK); a = a + 1; r--;
        end
        while (r >= 2) begin
            push({2'b00, 8'hAD});
            if (first) push_addr(a);
            push({2'b00, pat(d, seed)}); push({2'b01, pat(d + 1, seed)}); d += 2;
            push(MARK); a = a + 2; r -= 2; first = 1'b0;
        end
        push({2'b01, 8'h04}); push(MARK);
        if (r == 1) begin
            push({2'b01, 8'h06});
            push({2'b00, 8'h02}); push_addr(a); push({2'b01, pat(d, seed)});
            push(MARK);
            push({2'b01, 8'h04});
        end
    endtask

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic run_job(input logic [23:0] a, input int len, input int bk,
                           input logic st, input logic gp, input logic [7:0] sd);
        int guard;
        @(negedge clk);
        cap_n = 0; di_ptr = 0; cur_len = len; busy_k = bk; busy_seen = 0;
        stall = st; gap = gp; seed = sd; seen_done = 1'b0;
        gen_expected(a, len);
        start = 1'b1; start_addr = a; length = 16'(len);
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (!seen_done && guard < 5000) begin @(negedge clk); guard++; end
        check(seen_done, "R10 done seen", int'(seen_done), 1);
        repeat (4) @(negedge clk);
    endtask

    task automatic cmp_stream(input string req);
        int bad;
        bad = -1;
        for (int i = 0; i < exp_n && i < cap_n; i++)
            if (bad < 0 && cap[i] !== exp_s[i]) bad = i;
        if (bad >= 0) check(1'b0, req, int'(cap[bad]), int'(exp_s[bad]));
        else check(cap_n == exp_n, req, cap_n, exp_n);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        check(!busy && !done && !tx_valid && !din_ready && !poll_req, "R1 reset idle",
              {busy, done, tx_valid, din_ready, poll_req}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            run_job(VEC[v][63:40], int'(VEC[v][39:24]), int'(VEC[v][23:16]),
                    VEC[v][8], VEC[v][0], 8'(v * 11 + 3));
            // R3 R4 R5 R6 R7 R8 R11 R12: exact frame and poll-marker stream
            cmp_stream("R3/R4/R5/R6/R7/R8/R11/R12 stream");
            check(seen_cnt == VEC[v][39:24], "R10 written count", int'(seen_cnt), int'(VEC[v][39:24]));
            check(!seen_err, "R9 no error on normal job", int'(seen_err), 0);
        end

        // R2: zero length
        run_job(24'h000400, 0, 0, 1'b0, 1'b0, 8'h10);
        check(cap_n == 0, "R2 no frames for zero length", cap_n, 0);
        check(seen_cnt == 0 && !seen_err, "R2 zero count no error", int'(seen_cnt), 0);

        // R9: poll timeout after the first pair frame (4 busy answers)
        run_job(24'h000200, 4, 20, 1'b0, 1'b0, 8'h20);
        exp_n = 7;
        cmp_stream("R9 stream stops at timeout");
        check(seen_err, "R9 error flagged", int'(seen_err), 1);
        check(seen_cnt == 2, "R9 R10 count at abort", int'(seen_cnt), 2);

        // R9: the block recovers for a normal job after an abort
        run_job(24'h000301, 3, 0, 1'b0, 1'b0, 8'h30);
        cmp_stream("R9 R4 R5 stream after abort");
        check(!seen_err && seen_cnt == 3, "R9 clean job after abort", int'(seen_cnt), 3);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule